// File: doc/BRIEF.md
# Instruction Decoder with Constant Generator

This block takes one 16-bit instruction word of a register-oriented CPU and breaks it into the control fields the rest of the pipeline needs. It sorts the word into one of three formats: two-operand, single-operand or conditional jump. It then reports the operation code, the source and destination register numbers, the addressing modes and the byte/word flag. It also reports how many extension words follow the instruction in the instruction stream.

Certain pairs of source register and mode stand for a built-in constant instead of a real operand. When the word uses one of these pairs, the decoder reports the constant and counts no extension word for the source. For jump words, the decoder tests the condition against the status flags it is given and computes the target address from the current PC.

All results are registered, so they appear one clock after the word is presented. The block reads no operands and executes nothing.

Top module: `instr_decoder`

## Requirements
- R1: While rst_n is low at a rising clock edge, every output is cleared to zero, including fmt_o (0 = none) and illegal_o.
- R2: Each output reflects the inputs sampled at the previous rising edge. fmt_o encodes 0 = none, 1 = single-operand, 2 = jump and 3 = two-operand. A word whose bits 15:13 are 001 is a jump. A word whose bits 15:12 are 4 or more is two-operand. A word whose bits 15:10 are 000100 and whose bits 9:7 are not 111 is single-operand.
- R3: For a two-operand word, op_o is bits 15:12, src_reg_o is bits 11:8, dst_mode_o is bit 7, byte_op_o is bit 6, src_mode_o is bits 5:4 and dst_reg_o is bits 3:0.
- R4: For a single-operand word, op_o is {0, bits 9:7} (for example 4 = push, 5 = call, 6 = return from interrupt), byte_op_o is bit 6, src_mode_o is bits 5:4 and src_reg_o is bits 3:0. dst_reg_o and dst_mode_o are zero.
- R5: The source needs one extension word when the mode is 01 and the register is not R3 (indexed, symbolic via R0, or absolute via R2). It also needs one when the mode is 11 and the register is R0 (immediate). Every other source needs none; this includes modes 10 and 11 on other registers.
- R6: A two-operand word with dst_mode_o = 1 adds one extension word. ext_words_o is the sum of the source and destination counts, so it is 0, 1 or 2.
- R7: Source R3 gives const_valid_o = 1, with the value 0, 1, 2 or 0xFFFF for modes 00, 01, 10 and 11 respectively.
- R8: Source R2 gives const_valid_o = 1 with the value 4 for mode 10 and 8 for mode 11. Modes 00 and 01 on R2 give no constant.
- R9: For a jump, op_o is {0, bits 12:10}. The flag input maps flags[0] = C, flags[1] = Z, flags[2] = N and flags[3] = V. jump_taken_o is set as follows: condition 0 when Z = 0, 1 when Z = 1, 2 when C = 0, 3 when C = 1, 4 when N = 1, 5 when N xor V = 0, 6 when N xor V = 1, and 7 always.
- R10: For a jump, jump_target_o = pc_value + 2 + 2 × sign-extended bits 9:0, taken modulo 2^16. For any word that is not a jump, jump_target_o and jump_taken_o are zero.
- R11: A word that matches no format sets illegal_o to 1, and every other output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_word | input | 16 | Instruction word to decode |
| pc_value | input | 16 | Address of the instruction word |
| flags | input | 4 | Status flags {V,N,Z,C} |
| fmt_o | output | 2 | Format class |
| op_o | output | 4 | Operation / condition code |
| src_reg_o | output | 4 | Source (or single operand) register |
| src_mode_o | output | 2 | Source addressing mode |
| dst_reg_o | output | 4 | Destination register |
| dst_mode_o | output | 1 | Destination addressing mode |
| byte_op_o | output | 1 | Byte operation flag |
| ext_words_o | output | 2 | Extension words that follow |
| const_valid_o | output | 1 | Source replaced by a constant |
| const_value_o | output | 16 | Constant value |
| jump_taken_o | output | 1 | Jump condition satisfied |
| jump_target_o | output | 16 | Jump destination |
| illegal_o | output | 1 | Word matches no format |

## Verification
On every cycle the assertions check four things: jump words are classified as jumps, the unconditional jump is always taken, an illegal word leaves every other output quiet, and the target and taken outputs stay zero outside jumps. They also check that the extension count never reaches 3. Only the bench scenarios can show the field positions, each constant value, the extension count for each mode and register pairing, and the branch arithmetic at its offset extremes and at address wrap.

// File: rtl/dec_pkg.sv
// Shared widths, format codes and the decoded-field record for the decoder.
package dec_pkg;
    localparam int WORD_W = 16;
    localparam int REG_W  = 4;
    localparam int OP_W   = 4;
    localparam int MODE_W = 2;
    localparam int EXT_W  = 2;
    localparam int FLAG_W = 4;
    localparam int OFFS_W = 10;
    localparam int COND_W = 3;
    localparam int FLG_C  = 0;
    localparam int FLG_Z  = 1;
    localparam int FLG_N  = 2;
    localparam int FLG_V  = 3;
    localparam logic [REG_W-1:0] REG_PC = 4'd0;
    localparam logic [REG_W-1:0] REG_CA = 4'd2;
    localparam logic [REG_W-1:0] REG_CB = 4'd3;

    typedef enum logic [1:0] {
        FMT_NONE   = 2'd0,
        FMT_SINGLE = 2'd1,
        FMT_JUMP   = 2'd2,
        FMT_DOUBLE = 2'd3
    } fmt_t;

    typedef struct packed {
        fmt_t              fmt;
        logic [OP_W-1:0]   op;
        logic [REG_W-1:0]  src_reg;
        logic [MODE_W-1:0] src_mode;
        logic [REG_W-1:0]  dst_reg;
        logic              dst_mode;
        logic              byte_op;
        logic              illegal;
    } fields_t;
endpackage

// File: rtl/dec_fields.sv
// Classifies an instruction word and extracts its register, mode and
// operation fields. Assumes the three format layouts are mutually exclusive
// in the order jump, two-operand, single-operand; anything else is illegal.
module dec_fields
    import dec_pkg::*;
(
    input  logic [WORD_W-1:0] instr,
    output fields_t           fld
);
    // Pick the format and slice the fields belonging to it.
    always_comb begin
        fld     = '0;
        fld.fmt = FMT_NONE;
        if (instr[15:13] == 3'b001) begin
            fld.fmt = FMT_JUMP;
            fld.op  = {1'b0, instr[12:10]};
        end else if (instr[15:12] >= 4'h4) begin
            fld.fmt      = FMT_DOUBLE;
            fld.op       = instr[15:12];
            fld.src_reg  = instr[11:8];
            fld.dst_mode = instr[7];
            fld.byte_op  = instr[6];
            fld.src_mode = instr[5:4];
            fld.dst_reg  = instr[3:0];
        end else if (instr[15:10] == 6'b000100 && instr[9:7] != 3'b111) begin
            fld.fmt      = FMT_SINGLE;
            fld.op       = {1'b0, instr[9:7]};
            fld.byte_op  = instr[6];
            fld.src_mode = instr[5:4];
            fld.src_reg  = instr[3:0];
        end else begin
            fld.illegal = 1'b1;
        end
    end
endmodule

// File: rtl/dec_constgen.sv
// Replaces constant-generator register/mode pairs with their value and counts
// the extension words of the instruction. Assumes dst_mode is zero for any
// format without a destination operand.
module dec_constgen
    import dec_pkg::*;
(
    input  logic              has_src,
    input  logic [REG_W-1:0]  src_reg,
    input  logic [MODE_W-1:0] src_mode,
    input  logic              dst_mode,
    output logic              const_valid,
    output logic [WORD_W-1:0] const_value,
    output logic [EXT_W-1:0]  ext_words
);
    logic src_ext;

    // Produce the built-in constant for the R3 and R2 encodings.
    always_comb begin
        const_valid = 1'b0;
        const_value = '0;
        if (has_src && src_reg == REG_CB) begin
            const_valid = 1'b1;
            unique case (src_mode)
                2'b00:   const_value = WORD_W'(0);
                2'b01:   const_value = WORD_W'(1);
                2'b10:   const_value = WORD_W'(2);
                default: const_value = '1;
            endcase
        end else if (has_src && src_reg == REG_CA && src_mode[1]) begin
            const_valid = 1'b1;
            const_value = src_mode[0] ? WORD_W'(8) : WORD_W'(4);
        end
    end

    // Count the source and destination words that follow the opcode.
    always_comb begin
        src_ext = has_src &&
                  ((src_mode == 2'b01 && src_reg != REG_CB) ||
                   (src_mode == 2'b11 && src_reg == REG_PC));
        ext_words = EXT_W'(src_ext) + EXT_W'(dst_mode);
    end
endmodule

// File: rtl/dec_jump.sv
// Evaluates a jump condition against the flags and forms the word-scaled
// target. Assumes pc is the address of the jump word itself.
module dec_jump
    import dec_pkg::*;
(
    input  logic              is_jump,
    input  logic [WORD_W-1:0] instr,
    input  logic [WORD_W-1:0] pc,
    input  logic [FLAG_W-1:0] flags,
    output logic              taken,
    output logic [WORD_W-1:0] target
);
    localparam int PAD_W = WORD_W - OFFS_W - 1;
    logic              cond_ok;
    logic              n_xor_v;
    logic [WORD_W-1:0] disp;

    // Decide whether the selected condition holds.
    always_comb begin
        n_xor_v = flags[FLG_N] ^ flags[FLG_V];
        unique case (instr[12:10])
            3'd0:    cond_ok = !flags[FLG_Z];
            3'd1:    cond_ok = flags[FLG_Z];
            3'd2:    cond_ok = !flags[FLG_C];
            3'd3:    cond_ok = flags[FLG_C];
            3'd4:    cond_ok = flags[FLG_N];
            3'd5:    cond_ok = !n_xor_v;
            3'd6:    cond_ok = n_xor_v;
            default: cond_ok = 1'b1;
        endcase
    end

    // Sign-extend the offset, scale by two and add to the next-word address.
    always_comb begin
        disp   = {{PAD_W{instr[OFFS_W-1]}}, instr[OFFS_W-1:0], 1'b0};
        taken  = is_jump && cond_ok;
        target = is_jump ? (pc + WORD_W'(2) + disp) : '0;
    end
endmodule

// File: rtl/instr_decoder.sv
// Top of the instruction decoder: combines field extraction, the constant
// generator and jump evaluation, and registers every result once.
// Assumes pc_value and flags belong to the word presented on instr_word.
module instr_decoder
    import dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       instr_word,
    input  logic [15:0]       pc_value,
    input  logic [3:0]        flags,
    output logic [1:0]        fmt_o,
    output logic [3:0]        op_o,
    output logic [3:0]        src_reg_o,
    output logic [1:0]        src_mode_o,
    output logic [3:0]        dst_reg_o,
    output logic              dst_mode_o,
    output logic              byte_op_o,
    output logic [1:0]        ext_words_o,
    output logic              const_valid_o,
    output logic [15:0]       const_value_o,
    output logic              jump_taken_o,
    output logic [15:0]       jump_target_o,
    output logic              illegal_o
);
    fields_t           fld_d, fld_q;
    logic              cv_d, cv_q;
    logic [WORD_W-1:0] cval_d, cval_q;
    logic [EXT_W-1:0]  ext_d, ext_q;
    logic              tk_d, tk_q;
    logic [WORD_W-1:0] tgt_d, tgt_q;
    logic              has_src;
    logic              is_jump;

    dec_fields u_fields (
        .instr (instr_word),
        .fld   (fld_d)
    );

    // Operands exist only for the single- and two-operand formats.
    always_comb begin
        has_src = (fld_d.fmt == FMT_SINGLE) || (fld_d.fmt == FMT_DOUBLE);
        is_jump = (fld_d.fmt == FMT_JUMP);
    end

    dec_constgen u_constgen (
        .has_src     (has_src),
        .src_reg     (fld_d.src_reg),
        .src_mode    (fld_d.src_mode),
        .dst_mode    (fld_d.dst_mode),
        .const_valid (cv_d),
        .const_value (cval_d),
        .ext_words   (ext_d)
    );

    dec_jump u_jump (
        .is_jump (is_jump),
        .instr   (instr_word),
        .pc      (pc_value),
        .flags   (flags),
        .taken   (tk_d),
        .target  (tgt_d)
    );

    // Output register stage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_q  <= '0;
            cv_q   <= 1'b0;
            cval_q <= '0;
            ext_q  <= '0;
            tk_q   <= 1'b0;
            tgt_q  <= '0;
        end else begin
            fld_q  <= fld_d;
            cv_q   <= cv_d;
            cval_q <= cval_d;
            ext_q  <= ext_d;
            tk_q   <= tk_d;
            tgt_q  <= tgt_d;
        end
    end

    assign fmt_o         = fld_q.fmt;
    assign op_o          = fld_q.op;
    assign src_reg_o     = fld_q.src_reg;
    assign src_mode_o    = fld_q.src_mode;
    assign dst_reg_o     = fld_q.dst_reg;
    assign dst_mode_o    = fld_q.dst_mode;
    assign byte_op_o     = fld_q.byte_op;
    assign illegal_o     = fld_q.illegal;
    assign ext_words_o   = ext_q;
    assign const_valid_o = cv_q;
    assign const_value_o = cval_q;
    assign jump_taken_o  = tk_q;
    assign jump_target_o = tgt_q;

    a_r2_jump_class: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_word[15:13] == 3'b001) |=> (fmt_o == FMT_JUMP));

    a_r9_jmp_always: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_word[15:10] == 6'b001111) |=> jump_taken_o);

    a_r11_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (fmt_o == FMT_NONE && ext_words_o == 2'd0 &&
                       !const_valid_o && !jump_taken_o && jump_target_o == 16'd0));

    a_r6_ext_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ext_words_o != 2'd3);

    a_r10_target_only_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_o != FMT_JUMP) |-> (jump_target_o == 16'd0 && !jump_taken_o));
endmodule

// File: tb/test_instr_decoder.sv
`timescale 1ns/1ps
module test_instr_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr_word = 16'h0000;
    logic [15:0] pc_value = 16'h0000;
    logic [3:0]  flags = 4'h0;
    logic [1:0]  fmt_o;
    logic [3:0]  op_o, src_reg_o, dst_reg_o;
    logic [1:0]  src_mode_o, ext_words_o;
    logic        dst_mode_o, byte_op_o, const_valid_o, jump_taken_o, illegal_o;
    logic [15:0] const_value_o, jump_target_o;
    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    instr_decoder i_instr_decoder (
        .clk(clk), .rst_n(rst_n), .instr_word(instr_word), .pc_value(pc_value),
        .flags(flags), .fmt_o(fmt_o), .op_o(op_o), .src_reg_o(src_reg_o),
        .src_mode_o(src_mode_o), .dst_reg_o(dst_reg_o), .dst_mode_o(dst_mode_o),
        .byte_op_o(byte_op_o), .ext_words_o(ext_words_o),
        .const_valid_o(const_valid_o), .const_value_o(const_value_o),
        .jump_taken_o(jump_taken_o), .jump_target_o(jump_target_o),
        .illegal_o(illegal_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Present a word at a falling edge; results are valid one falling edge later.
    task automatic apply(input logic [15:0] w, input logic [15:0] pc, input logic [3:0] f);
        @(negedge clk);
        instr_word = w; pc_value = pc; flags = f;
        @(negedge clk);
    endtask

    task automatic chk_ops(input string req, input int fmt, input int op, input int sr,
                           input int sm, input int dr, input int dm, input int b,
                           input int ext, input int cv, input int cval);
        chk(req, "fmt", fmt_o, fmt);
        chk(req, "op", op_o, op);
        chk(req, "src_reg", src_reg_o, sr);
        chk(req, "src_mode", src_mode_o, sm);
        chk(req, "dst_reg", dst_reg_o, dr);
        chk(req, "dst_mode", dst_mode_o, dm);
        chk(req, "byte", byte_op_o, b);
        chk(req, "ext", ext_words_o, ext);
        chk(req, "cvalid", const_valid_o, cv);
        chk(req, "cvalue", const_value_o, cval);
        chk(req, "taken", jump_taken_o, 0);
        chk(req, "target", jump_target_o, 0);
        chk(req, "illegal", illegal_o, 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        apply(16'h40B2, 16'h1234, 4'hF);
        chk("R1", "fmt", fmt_o, 0);
        chk("R1", "illegal", illegal_o, 0);
        chk("R1", "ext", ext_words_o, 0);
        chk("R1", "op", op_o, 0);
        chk("R1", "target", jump_target_o, 0);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic t_double;
        apply(16'h4031, 16'hF800, 4'h0);  chk_ops("R3", 3, 4, 0, 3, 1, 0, 0, 1, 0, 0);
        apply(16'h40B2, 16'hF800, 4'h0);  chk_ops("R6", 3, 4, 0, 3, 2, 1, 0, 2, 0, 0);
        apply(16'hF0B5, 16'hF800, 4'h0);  chk_ops("R6", 3, 15, 0, 3, 5, 1, 0, 2, 0, 0);
        apply(16'h4515, 16'h0, 4'h0);     chk_ops("R5", 3, 4, 5, 1, 5, 0, 0, 1, 0, 0);
        apply(16'h4525, 16'h0, 4'h0);     chk_ops("R5", 3, 4, 5, 2, 5, 0, 0, 0, 0, 0);
        apply(16'h4535, 16'h0, 4'h0);     chk_ops("R5", 3, 4, 5, 3, 5, 0, 0, 0, 0, 0);
        apply(16'h4014, 16'h0, 4'h0);     chk_ops("R5", 3, 4, 0, 1, 4, 0, 0, 1, 0, 0);
        apply(16'h4024, 16'h0, 4'h0);     chk_ops("R5", 3, 4, 0, 2, 4, 0, 0, 0, 0, 0);
        apply(16'h4212, 16'h0, 4'h0);     chk_ops("R8", 3, 4, 2, 1, 2, 0, 0, 1, 0, 0);
        apply(16'h4202, 16'h0, 4'h0);     chk_ops("R8", 3, 4, 2, 0, 2, 0, 0, 0, 0, 0);
    endtask

    task automatic t_constants;
        apply(16'h43C2, 16'h0, 4'h0);     chk_ops("R7", 3, 4, 3, 0, 2, 1, 1, 1, 1, 16'h0000);
        apply(16'hD3D2, 16'h0, 4'h0);     chk_ops("R7", 3, 13, 3, 1, 2, 1, 1, 1, 1, 16'h0001);
        apply(16'h4322, 16'h0, 4'h0);     chk_ops("R7", 3, 4, 3, 2, 2, 0, 0, 0, 1, 16'h0002);
        apply(16'h4332, 16'h0, 4'h0);     chk_ops("R7", 3, 4, 3, 3, 2, 0, 0, 0, 1, 16'hFFFF);
        apply(16'h4222, 16'h0, 4'h0);     chk_ops("R8", 3, 4, 2, 2, 2, 0, 0, 0, 1, 16'h0004);
        apply(16'h4232, 16'h0, 4'h0);     chk_ops("R8", 3, 4, 2, 3, 2, 0, 0, 0, 1, 16'h0008);
    endtask

    task automatic t_single;
        apply(16'h1204, 16'h0, 4'h0);     chk_ops("R4", 1, 4, 4, 0, 0, 0, 0, 0, 0, 0);
        apply(16'h12B0, 16'h0, 4'h0);     chk_ops("R4", 1, 5, 0, 3, 0, 0, 0, 1, 0, 0);
        apply(16'h1232, 16'h0, 4'h0);     chk_ops("R4", 1, 4, 2, 3, 0, 0, 0, 0, 1, 8);
        apply(16'h1300, 16'h0, 4'h0);     chk_ops("R4", 1, 6, 0, 0, 0, 0, 0, 0, 0, 0);
        apply(16'h1040, 16'h0, 4'h0);     chk_ops("R4", 1, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    endtask

    task automatic chk_illegal(input logic [15:0] w);
        apply(w, 16'hF800, 4'hF);
        chk("R11", "illegal", illegal_o, 1);
        chk("R11", "fmt", fmt_o, 0);
        chk("R11", "ext", ext_words_o, 0);
        chk("R11", "cvalid", const_valid_o, 0);
        chk("R11", "op", op_o, 0);
        chk("R11", "taken", jump_taken_o, 0);
        chk("R11", "target", jump_target_o, 0);
    endtask

    task automatic t_illegal;
        chk_illegal(16'h1380);
        chk_illegal(16'h0ABC);
        chk_illegal(16'h1C00);
    endtask

    task automatic chk_jump(input int cond, input logic [9:0] off, input logic [15:0] pc,
                            input logic [3:0] f, input int exp_tk, input int exp_tgt);
        apply(16'h2000 | 16'(cond << 10) | {6'b0, off}, pc, f);
        chk("R9", "fmt", fmt_o, 2);
        chk("R9", "op", op_o, cond);
        chk("R9", "taken", jump_taken_o, exp_tk);
        chk("R10", "target", jump_target_o, exp_tgt);
        chk("R9", "ext", ext_words_o, 0);
    endtask

    task automatic t_jumps;
        chk_jump(0, 10'h3FF, 16'hF800, 4'b0000, 1, 16'hF800);
        chk_jump(0, 10'h3FF, 16'hF800, 4'b0010, 0, 16'hF800);
        chk_jump(1, 10'h3FF, 16'hF800, 4'b0010, 1, 16'hF800);
        chk_jump(1, 10'h3FF, 16'hF800, 4'b0000, 0, 16'hF800);
        chk_jump(2, 10'h200, 16'hF800, 4'b0000, 1, 16'hF402);
        chk_jump(2, 10'h200, 16'hF800, 4'b0001, 0, 16'hF402);
        chk_jump(3, 10'h1FF, 16'hF800, 4'b0001, 1, 16'hFC00);
        chk_jump(3, 10'h1FF, 16'hF800, 4'b0000, 0, 16'hFC00);
        chk_jump(4, 10'h000, 16'hFFFE, 4'b0100, 1, 16'h0000);
        chk_jump(4, 10'h000, 16'hFFFE, 4'b0000, 0, 16'h0000);
        chk_jump(5, 10'h001, 16'h1000, 4'b1100, 1, 16'h1004);
        chk_jump(5, 10'h001, 16'h1000, 4'b0100, 0, 16'h1004);
        chk_jump(6, 10'h001, 16'h1000, 4'b1000, 1, 16'h1004);
        chk_jump(6, 10'h001, 16'h1000, 4'b0000, 0, 16'h1004);
        chk_jump(7, 10'h002, 16'h1000, 4'b0000, 1, 16'h1006);
        chk_jump(7, 10'h002, 16'h1000, 4'b1111, 1, 16'h1006);
    endtask

    task automatic t_reset_midrun;
        apply(16'h4031, 16'h0, 4'h0);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "fmt after reset", fmt_o, 0);
        chk("R1", "ext after reset", ext_words_o, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_double();
        t_constants();
        t_single();
        t_illegal();
        t_jumps();
        t_reset_midrun();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule